// File: doc/BRIEF.md
# Region-Policed Word Store Controller

This block sits in front of a register-modelled store of 128 words of 32 bits and decides, word by word, how a write may change what is stored. The lowest five words are bit-clear-only: a write can only drop ones to zeros, and a separate bulk-reset strobe refills that region with ones. Words 5 and 6 are down-counters: a write is taken only when its value does not exceed the stored count. Words 7 to 127 are plain words that a write overwrites in full, unless the group that holds them has been locked.

Outside the store, address 255 is a 32-bit lock word. Its bits can only be set, and bit j protects general words 4j to 4j+3. Addresses 253 and 254 show the low and high halves of a fixed 64-bit identifier, which cannot be written. Every other address from 128 up reads as zero and refuses writes.

A small state machine sequences the work. In `ST_IDLE` the block serves reads directly. A write strobe moves it to `ST_WRITE` (transition *start write*), where the addressed word is read, filtered and committed. It then returns to `ST_IDLE` (transition *write done*). A bulk-reset strobe moves it to `ST_ERASE` (transition *start erase*), where the bit-clear region is refilled, and it then returns to `ST_IDLE` (transition *erase done*). Strobes that arrive outside `ST_IDLE` are dropped.

Top module: `wpm_ctrl`

## Requirements
- R1: After reset, words 0 to 6 read FFFFFFFFh, words 7 to 127 and the lock word (address 255) read 0, and rvalid, wr_ok and wr_rej are low.
- R2: A read strobe sampled in ST_IDLE, with no write or bulk-reset strobe at the same edge, gives rdata and a one-cycle rvalid pulse from the next clock edge. Addresses 128 to 252 read as 0.
- R3: A write to words 0 to 4 is accepted and stores old AND new, so no stored 0 ever becomes 1.
- R4: A bulk-reset strobe (otp_rst) sets all bits of words 0 to 4 to 1 and leaves every other word unchanged. It reports no write status.
- R5: A write to word 5 or 6 is accepted and stored when its value is less than or equal to the stored value. Otherwise it is rejected and the word is unchanged.
- R6: An accepted write to words 7 to 127 replaces all 32 bits with the written data.
- R7: A write to address 255 is accepted and ORs the data into the lock word, so lock bits never clear. While lock bit j is 1, writes to general words 4j to 4j+3 (only words 7 and above) are rejected and leave them unchanged.
- R8: Address 253 reads identifier bits 31:0 and address 254 reads bits 63:32. Writes to 128 to 254 are rejected and change nothing.
- R9: For a write strobe sampled at edge k, exactly one of wr_ok or wr_rej is high for the single cycle between edges k+1 and k+2.
- R10: In ST_IDLE the strobe priority is otp_rst, then wr_stb, then rd_stb. A lower strobe given with a higher one is dropped. Any strobe sampled in ST_WRITE or ST_ERASE is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rd_stb | input | 1 | Read request for addr |
| wr_stb | input | 1 | Write request of wdata to addr |
| otp_rst | input | 1 | Bulk refill of the bit-clear region |
| addr | input | 8 | Word address |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Registered read data |
| rvalid | output | 1 | rdata valid pulse |
| wr_ok | output | 1 | Write accepted pulse |
| wr_rej | output | 1 | Write rejected pulse |

## Verification
The bench checks the bit-clear merge with patterns that try to set cleared bits. A design that overwrote the word would show them as 1. On the counters it tries larger, equal and smaller values; an inverted or strict comparison would either let the count rise or refuse an equal value. For the lock it probes the first word covered by a lock bit, its neighbour outside the group, and a bit-clear word inside a locked group, and it tries to clear the lock by writing zero. Finally it sends strobes during a write and several strobes at once. A design with a wrong priority or a missing busy guard would produce a stray rvalid or an unwanted overwrite.

// File: rtl/wpm_pkg.sv
package wpm_pkg;
    localparam int unsigned NWORDS    = 128;
    localparam int unsigned MEM_AW    = $clog2(NWORDS);
    localparam int unsigned OTP_LAST  = 4;
    localparam int unsigned CNT_FIRST = 5;
    localparam int unsigned CNT_LAST  = 6;
    localparam int unsigned ID_LO     = 253;
    localparam int unsigned ID_HI     = 254;
    localparam int unsigned LOCK_ADDR = 255;

    typedef enum logic [1:0] {ST_IDLE, ST_WRITE, ST_ERASE} state_t;
    typedef enum logic [2:0] {RG_OTP, RG_CNT, RG_GEN, RG_LOCK, RG_IDLO, RG_IDHI, RG_NONE} region_t;
endpackage

// File: rtl/wpm_decode.sv
module wpm_decode
    import wpm_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic [ADDR_W-1:0] addr,
    output region_t           region
);
    logic [31:0] a32;

    always_comb begin
        a32 = {{(32-ADDR_W){1'b0}}, addr};
        if (a32 <= OTP_LAST)                         region = RG_OTP;
        else if (a32 >= CNT_FIRST && a32 <= CNT_LAST) region = RG_CNT;
        else if (a32 < NWORDS)                       region = RG_GEN;
        else if (a32 == LOCK_ADDR)                   region = RG_LOCK;
        else if (a32 == ID_LO)                       region = RG_IDLO;
        else if (a32 == ID_HI)                       region = RG_IDHI;
        else                                         region = RG_NONE;
    end
endmodule

// File: rtl/wpm_policy.sv
module wpm_policy
    import wpm_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  region_t           region,
    input  logic [DATA_W-1:0] old_word,
    input  logic [DATA_W-1:0] new_word,
    input  logic              locked,
    output logic              accept,
    output logic              mem_we,
    output logic              lock_we,
    output logic [DATA_W-1:0] merged
);
    always_comb begin
        accept  = 1'b0;
        mem_we  = 1'b0;
        lock_we = 1'b0;
        merged  = old_word;
        unique case (region)
            RG_OTP: begin
                accept = 1'b1;
                mem_we = 1'b1;
                merged = old_word & new_word;
            end
            RG_CNT: begin
                accept = (new_word <= old_word);
                mem_we = accept;
                merged = new_word;
            end
            RG_GEN: begin
                accept = !locked;
                mem_we = accept;
                merged = new_word;
            end
            RG_LOCK: begin
                accept  = 1'b1;
                lock_we = 1'b1;
                merged  = old_word | new_word;
            end
            RG_IDLO, RG_IDHI, RG_NONE: begin
                accept = 1'b0;
            end
            default: accept = 1'b0;
        endcase
    end
endmodule

// File: rtl/wpm_array.sv
module wpm_array
    import wpm_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int AW     = MEM_AW
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [AW-1:0]     waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              erase,
    input  logic [AW-1:0]     raddr,
    output logic [DATA_W-1:0] rdata
);
    logic [DATA_W-1:0] mem_q [NWORDS];

    for (genvar i = 0; i < int'(NWORDS); i++) begin : g_word
        localparam logic [DATA_W-1:0] RST_V = (i <= int'(CNT_LAST)) ? {DATA_W{1'b1}} : {DATA_W{1'b0}};
        localparam bit IN_OTP = (i <= int'(OTP_LAST));
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                mem_q[i] <= RST_V;
            end else if (erase && IN_OTP) begin
                mem_q[i] <= {DATA_W{1'b1}};
            end else if (we && waddr == AW'(i)) begin
                mem_q[i] <= wdata;
            end
        end
    end

    assign rdata = mem_q[raddr];
endmodule

// File: rtl/wpm_ctrl.sv
module wpm_ctrl
    import wpm_pkg::*;
#(
    parameter int          DATA_W   = 32,
    parameter int          ADDR_W   = 8,
    parameter logic [63:0] ID_VALUE = 64'h0123_4567_89AB_CDEF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_stb,
    input  logic              wr_stb,
    input  logic              otp_rst,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic              rvalid,
    output logic              wr_ok,
    output logic              wr_rej
);
    localparam int AW        = MEM_AW;
    localparam int GRP_SHIFT = $clog2(NWORDS / DATA_W);
    localparam int LIDX_W    = $clog2(DATA_W);

    state_t            state_q, state_d;
    logic [ADDR_W-1:0] addr_q, cur_addr;
    logic [DATA_W-1:0] data_q, lock_q;
    logic [DATA_W-1:0] arr_rdata, old_word, merged, rd_word;
    logic [AW-1:0]     grp_word;
    logic [LIDX_W-1:0] lock_idx;
    region_t           region;
    logic              accept, mem_we, lock_we, do_write, rd_take;

    assign cur_addr = (state_q == ST_IDLE) ? addr : addr_q;
    assign grp_word = cur_addr[AW-1:0] >> GRP_SHIFT;
    assign lock_idx = grp_word[LIDX_W-1:0];
    assign do_write = (state_q == ST_WRITE);
    assign rd_take  = (state_q == ST_IDLE) && rd_stb && !wr_stb && !otp_rst;
    assign old_word = (region == RG_LOCK) ? lock_q : arr_rdata;

    wpm_decode #(.ADDR_W(ADDR_W)) u_dec (
        .addr   (cur_addr),
        .region (region)
    );

    wpm_array #(.DATA_W(DATA_W), .AW(AW)) u_arr (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (do_write && accept && mem_we),
        .waddr (addr_q[AW-1:0]),
        .wdata (merged),
        .erase (state_q == ST_ERASE),
        .raddr (cur_addr[AW-1:0]),
        .rdata (arr_rdata)
    );

    wpm_policy #(.DATA_W(DATA_W)) u_pol (
        .region   (region),
        .old_word (old_word),
        .new_word (data_q),
        .locked   (lock_q[lock_idx]),
        .accept   (accept),
        .mem_we   (mem_we),
        .lock_we  (lock_we),
        .merged   (merged)
    );

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (otp_rst)     state_d = ST_ERASE;
                else if (wr_stb) state_d = ST_WRITE;
            end
            ST_WRITE: state_d = ST_IDLE;
            ST_ERASE: state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    // state register and request capture
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            addr_q  <= '0;
            data_q  <= '0;
        end else begin
            state_q <= state_d;
            if (state_q == ST_IDLE && wr_stb && !otp_rst) begin
                addr_q <= addr;
                data_q <= wdata;
            end
        end
    end

    // lock word
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                              lock_q <= '0;
        else if (do_write && accept && lock_we)  lock_q <= merged;
    end

    // read source selection
    always_comb begin
        unique case (region)
            RG_OTP, RG_CNT, RG_GEN: rd_word = arr_rdata;
            RG_LOCK:                rd_word = lock_q;
            RG_IDLO:                rd_word = ID_VALUE[31:0];
            RG_IDHI:                rd_word = ID_VALUE[63:32];
            default:                rd_word = '0;
        endcase
    end

    // outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rdata  <= '0;
            rvalid <= 1'b0;
            wr_ok  <= 1'b0;
            wr_rej <= 1'b0;
        end else begin
            rvalid <= rd_take;
            wr_ok  <= do_write && accept;
            wr_rej <= do_write && !accept;
            if (rd_take) rdata <= rd_word;
        end
    end
endmodule

// File: rtl/wpm_chk.sv
module wpm_chk
    import wpm_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              rd_stb,
    input logic              wr_stb,
    input logic              otp_rst,
    input logic              rvalid,
    input logic              wr_ok,
    input logic              wr_rej,
    input state_t            state_q,
    input logic [DATA_W-1:0] otp0,
    input logic [DATA_W-1:0] cnt5,
    input logic [DATA_W-1:0] lock
);
    AST_RD_NEXT:     assert property (@(posedge clk) disable iff (!rst_n) (state_q == ST_IDLE && rd_stb && !wr_stb && !otp_rst) |=> rvalid); // R2
    AST_RV_CAUSE:    assert property (@(posedge clk) disable iff (!rst_n) rvalid |-> $past(rd_stb)); // R2
    AST_OTP_NO_SET:  assert property (@(posedge clk) disable iff (!rst_n) ($past(state_q) != ST_ERASE) |-> ((otp0 & ~$past(otp0)) == '0)); // R3
    AST_ERASE_FILL:  assert property (@(posedge clk) disable iff (!rst_n) ($past(state_q) == ST_ERASE) |-> (otp0 == '1)); // R4
    AST_CNT_NO_UP:   assert property (@(posedge clk) disable iff (!rst_n) cnt5 <= $past(cnt5)); // R5
    AST_LOCK_STICKY: assert property (@(posedge clk) disable iff (!rst_n) (($past(lock) & ~lock) == '0)); // R7
    AST_STATUS_EXCL: assert property (@(posedge clk) disable iff (!rst_n) !(wr_ok && wr_rej)); // R9
    AST_STATUS_SRC:  assert property (@(posedge clk) disable iff (!rst_n) (wr_ok || wr_rej) |-> ($past(state_q) == ST_WRITE)); // R9
    AST_BUSY_DROP:   assert property (@(posedge clk) disable iff (!rst_n) (state_q != ST_IDLE) |=> !rvalid); // R10
endmodule

bind wpm_ctrl wpm_chk #(.DATA_W(DATA_W)) i_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .rd_stb  (rd_stb),
    .wr_stb  (wr_stb),
    .otp_rst (otp_rst),
    .rvalid  (rvalid),
    .wr_ok   (wr_ok),
    .wr_rej  (wr_rej),
    .state_q (state_q),
    .otp0    (u_arr.mem_q[0]),
    .cnt5    (u_arr.mem_q[5]),
    .lock    (lock_q)
);

// File: tb/test_wpm_ctrl.sv
module test_wpm_ctrl;
    localparam logic [63:0] IDV = 64'hFEED_5A5A_0BAD_C0DE;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        rd_stb = 1'b0, wr_stb = 1'b0, otp_rst = 1'b0;
    logic [7:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        rvalid, wr_ok, wr_rej;
    int          total = 0;
    int          bad = 0;

    always #10 clk = ~clk;

    wpm_ctrl #(.ID_VALUE(IDV)) i_wpm_ctrl (
        .clk(clk), .rst_n(rst_n), .rd_stb(rd_stb), .wr_stb(wr_stb), .otp_rst(otp_rst),
        .addr(addr), .wdata(wdata), .rdata(rdata), .rvalid(rvalid), .wr_ok(wr_ok), .wr_rej(wr_rej)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d, output logic ok, output logic rej);
        @(negedge clk); addr = a; wdata = d; wr_stb = 1'b1;
        @(negedge clk); wr_stb = 1'b0;
        @(negedge clk); ok = wr_ok; rej = wr_rej;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d, output logic v);
        @(negedge clk); addr = a; rd_stb = 1'b1;
        @(negedge clk); rd_stb = 1'b0; v = rvalid; d = rdata;
    endtask

    task automatic rd_chk(input string tag, input logic [7:0] a, input logic [31:0] exp);
        logic [31:0] d; logic v;
        rd(a, d, v);
        chk({tag, " rvalid"}, {31'b0, v}, 32'd1);
        chk(tag, d, exp);
    endtask

    task automatic wr_chk(input string tag, input logic [7:0] a, input logic [31:0] d, input logic exp_ok);
        logic ok, rej;
        wr(a, d, ok, rej);
        chk({tag, " status"}, {30'b0, ok, rej}, exp_ok ? 32'd2 : 32'd1);
    endtask

    task automatic t_reset;
        @(negedge clk);
        chk("R1 outputs", {29'b0, rvalid, wr_ok, wr_rej}, 32'd0);
        rd_chk("R1 w0", 8'd0, 32'hFFFF_FFFF);
        rd_chk("R1 w6", 8'd6, 32'hFFFF_FFFF);
        rd_chk("R1 w7", 8'd7, 32'h0);
        rd_chk("R1 w127", 8'd127, 32'h0);
        rd_chk("R1 lock", 8'd255, 32'h0);
    endtask

    task automatic t_read;
        rd_chk("R2 w3", 8'd3, 32'hFFFF_FFFF);
        @(negedge clk);
        chk("R2 pulse", {31'b0, rvalid}, 32'd0);
        rd_chk("R2 hole", 8'd200, 32'h0);
    endtask

    task automatic t_otp;
        wr_chk("R3 w1a", 8'd1, 32'hF0F0_FFFF, 1'b1);
        rd_chk("R3 w1a rd", 8'd1, 32'hF0F0_FFFF);
        wr_chk("R3 w1b", 8'd1, 32'h0FFF_00FF, 1'b1);
        rd_chk("R3 w1b rd", 8'd1, 32'h00F0_00FF);
    endtask

    task automatic t_erase;
        wr_chk("R4 prep", 8'd7, 32'h1234_5678, 1'b1);
        @(negedge clk); otp_rst = 1'b1;
        @(negedge clk); otp_rst = 1'b0;
        chk("R4 no status", {30'b0, wr_ok, wr_rej}, 32'd0);
        @(negedge clk);
        chk("R4 no status2", {30'b0, wr_ok, wr_rej}, 32'd0);
        rd_chk("R4 w1", 8'd1, 32'hFFFF_FFFF);
        rd_chk("R4 w7 kept", 8'd7, 32'h1234_5678);
    endtask

    task automatic t_cnt;
        wr_chk("R5 down", 8'd5, 32'd100, 1'b1);
        rd_chk("R5 down rd", 8'd5, 32'd100);
        wr_chk("R5 up", 8'd5, 32'd200, 1'b0);
        rd_chk("R5 up rd", 8'd5, 32'd100);
        wr_chk("R5 equal", 8'd5, 32'd100, 1'b1);
        wr_chk("R5 w6 max", 8'd6, 32'hFFFF_FFFF, 1'b1);
        wr_chk("R5 w6 low", 8'd6, 32'd0, 1'b1);
        rd_chk("R5 w6 rd", 8'd6, 32'd0);
    endtask

    task automatic t_gen;
        wr_chk("R6 a", 8'd50, 32'hA5A5_A5A5, 1'b1);
        rd_chk("R6 a rd", 8'd50, 32'hA5A5_A5A5);
        wr_chk("R6 b", 8'd50, 32'h0000_0001, 1'b1);
        rd_chk("R6 b rd", 8'd50, 32'h0000_0001);
    endtask

    task automatic t_status;
        logic ok, rej;
        wr(8'd60, 32'h5, ok, rej);
        chk("R9 ok", {30'b0, ok, rej}, 32'd2);
        @(negedge clk);
        chk("R9 pulse end", {30'b0, wr_ok, wr_rej}, 32'd0);
    endtask

    task automatic t_lock;
        wr_chk("R7 set", 8'd255, 32'h0000_0006, 1'b1);
        wr_chk("R7 w9", 8'd9, 32'hDEAD_BEEF, 1'b0);
        rd_chk("R7 w9 rd", 8'd9, 32'h0);
        wr_chk("R7 w7", 8'd7, 32'h1, 1'b0);
        rd_chk("R7 w7 rd", 8'd7, 32'h1234_5678);
        wr_chk("R7 w12", 8'd12, 32'h0000_00CC, 1'b1);
        rd_chk("R7 w12 rd", 8'd12, 32'h0000_00CC);
        wr_chk("R7 w4 otp", 8'd4, 32'h0000_FFFF, 1'b1);
        rd_chk("R7 w4 rd", 8'd4, 32'h0000_FFFF);
        wr_chk("R7 clear try", 8'd255, 32'h0, 1'b1);
        rd_chk("R7 sticky", 8'd255, 32'h0000_0006);
    endtask

    task automatic t_id;
        rd_chk("R8 lo", 8'd253, IDV[31:0]);
        rd_chk("R8 hi", 8'd254, IDV[63:32]);
        wr_chk("R8 wr lo", 8'd253, 32'h0, 1'b0);
        rd_chk("R8 lo kept", 8'd253, IDV[31:0]);
        wr_chk("R8 wr hole", 8'd130, 32'h77, 1'b0);
        rd_chk("R8 hole rd", 8'd130, 32'h0);
    endtask

    task automatic t_busy;
        @(negedge clk); addr = 8'd70; wdata = 32'h0000_AAAA; wr_stb = 1'b1;
        @(negedge clk); wr_stb = 1'b0; rd_stb = 1'b1; addr = 8'd71;
        @(negedge clk); rd_stb = 1'b0;
        chk("R10 rd in write", {31'b0, rvalid}, 32'd0);
        chk("R10 wr status", {30'b0, wr_ok, wr_rej}, 32'd2);
        @(negedge clk); addr = 8'd0; wdata = 32'h0; otp_rst = 1'b1; wr_stb = 1'b1; rd_stb = 1'b1;
        @(negedge clk); otp_rst = 1'b0; wr_stb = 1'b0; rd_stb = 1'b0;
        chk("R10 rd dropped", {31'b0, rvalid}, 32'd0);
        @(negedge clk);
        chk("R10 wr dropped", {30'b0, wr_ok, wr_rej}, 32'd0);
        rd_chk("R10 w0", 8'd0, 32'hFFFF_FFFF);
        @(negedge clk); addr = 8'd72; wdata = 32'h99; wr_stb = 1'b1; rd_stb = 1'b1;
        @(negedge clk); wr_stb = 1'b0; rd_stb = 1'b0;
        chk("R10 rd under wr", {31'b0, rvalid}, 32'd0);
        @(negedge clk);
        chk("R10 wr wins", {30'b0, wr_ok, wr_rej}, 32'd2);
        rd_chk("R10 w72", 8'd72, 32'h99);
        rd_chk("R10 w70", 8'd70, 32'h0000_AAAA);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog act=running exp=finished");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset;
        t_read;
        t_otp;
        t_erase;
        t_cnt;
        t_gen;
        t_status;
        t_lock;
        t_id;
        t_busy;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule